// File: doc/BRIEF.md
# Asynchronous ROM Read Sequencer

This block lets a synchronous host fetch 16-bit words from an asynchronous 128K-word read-only memory that shares its data lines with other devices. The host offers a 17-bit word address with a valid/ready handshake. The sequencer then drives the memory address. It lowers the active-low chip select and, later, the active-low output strobe. It counts clock cycles until the part's access limits are met, latches the word and hands it back with a one-cycle valid pulse.

After both controls are released, the sequencer keeps its ready line low for a float interval. This gives the memory's output drivers time to turn off before any other device may use the shared lines. A request made while the sequencer is busy or floating is not lost. It waits on the handshake and is taken at the first ready cycle.

The speed grade is a parameter. A grade index selects the address-to-data, strobe-to-data and float times in nanoseconds, and the clock period is a second parameter. Each delay in cycles is worked out at elaboration as the ceiling of the time over the period, plus one cycle of margin. The output strobe is lowered late, so that it stays low only for the cycles the strobe-to-data time needs. When no read is in progress, the chip select is high and the memory stays in standby.

Top module: `rom_read_sequencer`

## Requirements
- R1: While reset is held and in the first cycle after it, romCeN and romOeN are 1, reqReady is 1, rdValid is 0 and rdData is 0.
- R2: A request is taken at a rising edge where reqValid and reqReady are both 1. romAddr shows the taken address from that edge on and does not change until the next taken request, whatever reqAddr does meanwhile.
- R3: romCeN is 0 for exactly ACC = ceil(tAcc/Tclk)+1 consecutive cycles, starting in the cycle right after the accepting edge.
- R4: romOeN is 0 only inside the romCeN window, and only for its final OE = ceil(tOe/Tclk)+1 cycles. It first goes low in window cycle ACC-OE+1, counted from 1.
- R5: romData is latched at the edge that ends the romCeN window. rdValid is 1 for exactly the one cycle after that edge, and both controls are already 1 in that cycle. rdData then equals the word the memory returned for romAddr.
- R6: reqReady is 0 from the accepting edge through the access and through a float of DF = ceil(tDf/Tclk)+1 cycles after release, and romCeN and romOeN stay 1 during the float. A request that is held during this time is taken at the first edge after reqReady returns to 1.
- R7: Whenever reqReady is 1, romCeN and romOeN are 1 (standby).
- R8: Grade indices 0 to 6 select tAcc of 55, 70, 90, 120, 150, 200 and 250 ns, tOe of 40, 40, 40, 50, 65, 75 and 75 ns, and tDf of 25, 25, 25, 30, 30, 40 and 60 ns.
- R9: rdData holds the last latched word until the next latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Host offers a read |
| reqAddr | input | ADDR_W | Word address of the offered read |
| reqReady | output | 1 | Sequencer can take a read this cycle |
| rdValid | output | 1 | One-cycle pulse: rdData carries a new word |
| rdData | output | DATA_W | Latched memory word |
| romAddr | output | ADDR_W | Address driven to the memory |
| romCeN | output | 1 | Memory chip select, active low |
| romOeN | output | 1 | Memory output strobe, active low |
| romData | input | DATA_W | Data lines from the memory |

## Verification
Reads are swept over address 0, all ones, and every walking-one and walking-zero pattern of the 17 address bits. This shows whether each address bit reaches the memory on its own line and whether each data bit comes back. The bench's memory model returns a junk word unless the address, chip select and output strobe have each been steady for their grade times in nanoseconds. A read that latches too early therefore shows up as a data miscompare, separate from the cycle-count checks on the select, strobe and float windows. Requests that are raised in the middle of an access and held through the float tell a queued request apart from one that is dropped or taken too early. They also check that the latched address ignores the changing request address.

// File: rtl/rom_read_pkg.sv
package rom_read_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACCESS = 2'd1,
    ST_FLOAT  = 2'd2
  } rdState_e;

  // strobes handed from control to datapath
  typedef struct packed {
    logic load;     // take request address
    logic ceOn;     // chip select active
    logic oeOn;     // output strobe active
    logic capture;  // latch memory word
  } rdStrobe_t;

  function automatic int accessNs(input int grade);
    case (grade)
      0: return 55;
      1: return 70;
      2: return 90;
      3: return 120;
      4: return 150;
      5: return 200;
      default: return 250;
    endcase
  endfunction

  function automatic int strobeNs(input int grade);
    case (grade)
      0, 1, 2: return 40;
      3: return 50;
      4: return 65;
      default: return 75;
    endcase
  endfunction

  function automatic int floatNs(input int grade);
    case (grade)
      0, 1, 2: return 25;
      3, 4: return 30;
      5: return 40;
      default: return 60;
    endcase
  endfunction

  // ceiling of time over period, plus one margin cycle
  function automatic int cyclesFor(input int ns, input int periodNs);
    return (ns + periodNs - 1) / periodNs + 1;
  endfunction

endpackage

// File: rtl/rom_read_ctrl.sv
module rom_read_ctrl
  import rom_read_pkg::*;
#(
  parameter int SPEED_GRADE   = 0,
  parameter int CLK_PERIOD_NS = 4
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  output logic      reqReady,
  output rdStrobe_t strb
);

  localparam int ACC_CYC  = cyclesFor(accessNs(SPEED_GRADE), CLK_PERIOD_NS);
  localparam int OE_CYC   = cyclesFor(strobeNs(SPEED_GRADE), CLK_PERIOD_NS);
  localparam int DF_CYC   = cyclesFor(floatNs(SPEED_GRADE), CLK_PERIOD_NS);
  localparam int OE_LEAD  = ACC_CYC - OE_CYC;
  localparam int MAX_CYC  = (ACC_CYC > DF_CYC) ? ACC_CYC : DF_CYC;
  localparam int CNT_W    = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] ACC_LAST = CNT_W'(ACC_CYC);
  localparam logic [CNT_W-1:0] DF_LAST  = CNT_W'(DF_CYC);
  localparam logic [CNT_W-1:0] OE_AFTER = CNT_W'(OE_LEAD);

  rdState_e         state;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (reqValid) begin
            state <= ST_ACCESS;
            cnt   <= CNT_W'(1);
          end
        end
        ST_ACCESS: begin
          if (cnt == ACC_LAST) begin
            state <= ST_FLOAT;
            cnt   <= CNT_W'(1);
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        ST_FLOAT: begin
          if (cnt == DF_LAST) begin
            state <= ST_IDLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        default: begin
          state <= ST_IDLE;
          cnt   <= '0;
        end
      endcase
    end
  end

  always_comb begin
    reqReady     = (state == ST_IDLE);
    strb.load    = (state == ST_IDLE) && reqValid;
    strb.ceOn    = (state == ST_ACCESS);
    strb.oeOn    = (state == ST_ACCESS) && (cnt > OE_AFTER);
    strb.capture = (state == ST_ACCESS) && (cnt == ACC_LAST);
  end

  AST_FLOAT_NO_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_FLOAT) |-> (!strb.ceOn && !strb.oeOn && !strb.load)); // R6

endmodule

// File: rtl/rom_read_dpath.sv
module rom_read_dpath
  import rom_read_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  rdStrobe_t         strb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] romData,
  output logic [ADDR_W-1:0] romAddr,
  output logic              romCeN,
  output logic              romOeN,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData
);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      romAddr <= '0;
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      if (strb.load)    romAddr <= reqAddr;
      if (strb.capture) rdData  <= romData;
      rdValid <= strb.capture;
    end
  end

  assign romCeN = ~strb.ceOn;
  assign romOeN = ~strb.oeOn;

  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (!romCeN && $past(!romCeN)) |-> $stable(romAddr)); // R2
  AST_CAPTURE_ENABLED: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |-> (strb.ceOn && strb.oeOn)); // R5
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |=> !rdValid); // R5
  AST_VALID_RELEASED: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> (romCeN && romOeN)); // R5

endmodule

// File: rtl/rom_read_sequencer.sv
module rom_read_sequencer
  import rom_read_pkg::*;
#(
  parameter int ADDR_W        = 17,
  parameter int DATA_W        = 16,
  parameter int SPEED_GRADE   = 0,
  parameter int CLK_PERIOD_NS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              reqReady,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] romAddr,
  output logic              romCeN,
  output logic              romOeN,
  input  logic [DATA_W-1:0] romData
);

  localparam int OE_LEAD = cyclesFor(accessNs(SPEED_GRADE), CLK_PERIOD_NS)
                         - cyclesFor(strobeNs(SPEED_GRADE), CLK_PERIOD_NS);

  rdStrobe_t strb;

  rom_read_ctrl #(
    .SPEED_GRADE  (SPEED_GRADE),
    .CLK_PERIOD_NS(CLK_PERIOD_NS)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqReady(reqReady),
    .strb    (strb)
  );

  rom_read_dpath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_dpath (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .reqAddr(reqAddr),
    .romData(romData),
    .romAddr(romAddr),
    .romCeN (romCeN),
    .romOeN (romOeN),
    .rdValid(rdValid),
    .rdData (rdData)
  );

  AST_OE_INSIDE_CE: assert property (@(posedge clk) disable iff (!rstN)
    !romOeN |-> !romCeN); // R4
  AST_IDLE_STANDBY: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (romCeN && romOeN)); // R7
  AST_READY_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(reqReady) |-> ($past(romCeN) && $past(romOeN))); // R6

  generate
    if (OE_LEAD > 0) begin : g_lateStrobe
      AST_OE_LATE: assert property (@(posedge clk) disable iff (!rstN)
        $fell(romOeN) |-> $past(!romCeN)); // R4
    end
  endgenerate

endmodule

// File: tb/rom_read_sequencer_bench.sv
`timescale 1ns/1ps
module rom_read_sequencer_bench;

  localparam int GRADE  = 0;
  localparam int PERIOD = 4;
  localparam int AW     = 17;
  localparam int DW     = 16;

  // R8: grade table kept in the bench
  function automatic int benchAcc(input int g);
    int t[7] = '{55, 70, 90, 120, 150, 200, 250};
    return t[g];
  endfunction
  function automatic int benchOe(input int g);
    int t[7] = '{40, 40, 40, 50, 65, 75, 75};
    return t[g];
  endfunction
  function automatic int benchDf(input int g);
    int t[7] = '{25, 25, 25, 30, 30, 40, 60};
    return t[g];
  endfunction

  localparam int TACC = benchAcc(GRADE);
  localparam int TOE  = benchOe(GRADE);
  localparam int TDF  = benchDf(GRADE);
  localparam int ACC  = (TACC + PERIOD - 1) / PERIOD + 1;
  localparam int OE   = (TOE + PERIOD - 1) / PERIOD + 1;
  localparam int DF   = (TDF + PERIOD - 1) / PERIOD + 1;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rstN, reqValid, reqReady, rdValid, romCeN, romOeN;
  logic [AW-1:0] reqAddr, romAddr;
  logic [DW-1:0] rdData, romData;

  int vectors = 0;
  int misses  = 0;
  logic done  = 1'b0;

  rom_read_sequencer #(
    .ADDR_W(AW), .DATA_W(DW), .SPEED_GRADE(GRADE), .CLK_PERIOD_NS(PERIOD)
  ) u_rom_read_sequencer (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqReady(reqReady), .rdValid(rdValid), .rdData(rdData),
    .romAddr(romAddr), .romCeN(romCeN), .romOeN(romOeN), .romData(romData)
  );

  function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
    return a[15:0] ^ 16'hA55A ^ {a[16], 15'h0};
  endfunction

  // memory model: a good word only after the address/select and strobe times
  int            aCnt = 0;
  int            oCnt = 0;
  logic [AW-1:0] prevAddr = '0;
  always @(negedge clk) begin
    if (romCeN) aCnt <= 0;
    else if (aCnt == 0 || romAddr != prevAddr) aCnt <= 1;
    else aCnt <= aCnt + 1;
    prevAddr <= romAddr;
    if (romCeN || romOeN) oCnt <= 0;
    else oCnt <= oCnt + 1;
  end
  always_comb begin
    if (!romCeN && !romOeN && aCnt * PERIOD >= TACC && oCnt * PERIOD >= TOE)
      romData = pat(romAddr);
    else
      romData = 16'hBAD0 ^ 16'(aCnt);
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
  endtask

  // starts at the first negedge after the accepting edge
  task automatic measureRead(input logic [AW-1:0] addr, input bit holdNext,
                             input logic [AW-1:0] nextAddr);
    int   ceCnt = 0, oeCnt = 0, oeFirst = 0, i = 1, fl = 0;
    logic addrOk = 1'b1, busyOk = 1'b1, ctlOff = 1'b1, pulseOk = 1'b1;
    while (!rdValid && i < 200) begin
      if (!romCeN) ceCnt++;
      if (!romOeN) begin
        oeCnt++;
        if (oeFirst == 0) oeFirst = i;
      end
      if (romAddr != addr) addrOk = 1'b0;
      if (reqReady) busyOk = 1'b0;
      if (holdNext && i == 3) begin
        reqValid = 1'b1;
        reqAddr  = nextAddr;
      end
      i++;
      @(negedge clk);
    end
    chk("R3 select window cycles", ceCnt, ACC);
    chk("R4 strobe window cycles", oeCnt, OE);
    chk("R4 strobe first cycle", oeFirst, ACC - OE + 1);
    chk("R2 address held", addrOk, 1);
    chk("R6 ready low while busy", busyOk, 1);
    chk("R5 valid cycle", i, ACC + 1);
    chk("R5 read data", rdData, pat(addr));
    chk("R5 controls released at valid", {romCeN, romOeN}, 2'b11);
    while (!reqReady && fl < 200) begin
      if (!romCeN || !romOeN) ctlOff = 1'b0;
      if (fl > 0 && rdValid) pulseOk = 1'b0;
      fl++;
      @(negedge clk);
    end
    chk("R6 float cycles", fl, DF);
    chk("R6 controls off in float", ctlOff, 1);
    chk("R5 valid single pulse", pulseOk, 1);
    chk("R9 data held", rdData, pat(addr));
    chk("R7 standby when ready", {romCeN, romOeN}, 2'b11);
    if (holdNext) begin
      @(negedge clk);
      reqValid = 1'b0;
      chk("R6 held request taken", {romCeN, romAddr}, {1'b0, nextAddr});
    end
  endtask

  task automatic doRead(input logic [AW-1:0] addr);
    reqValid = 1'b1;
    reqAddr  = addr;
    @(negedge clk);
    reqValid = 1'b0;
    measureRead(addr, 1'b0, '0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      misses++;
      $display("FAIL watchdog: actual timeout expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    rstN     = 1'b0;
    reqValid = 1'b0;
    reqAddr  = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {romCeN, romOeN, reqReady, rdValid}, 4'b1110);
    chk("R1 reset data", rdData, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 after reset", {romCeN, romOeN, reqReady, rdValid}, 4'b1110);
    repeat (3) @(negedge clk);
    chk("R7 idle standby", {romCeN, romOeN}, 2'b11);

    doRead('0);
    doRead('1);
    for (int b = 0; b < AW; b++) begin
      doRead(AW'(1) << b);
      doRead(~(AW'(1) << b));
    end

    // chained held requests (R6), raised mid-access
    reqValid = 1'b1;
    reqAddr  = 17'h0_1234;
    @(negedge clk);
    reqValid = 1'b0;
    measureRead(17'h0_1234, 1'b1, 17'h1_ABCD);
    measureRead(17'h1_ABCD, 1'b1, 17'h0_8001);
    measureRead(17'h0_8001, 1'b0, '0);

    repeat (5) @(negedge clk);
    chk("R9 data held when idle", rdData, pat(17'h0_8001));
    chk("R7 standby after run", {romCeN, romOeN, rdValid}, 3'b110);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule